// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out load-multiple and store-multiple operations for a processor core. A one-cycle start strobe hands it a 16-bit register list, a 32-bit base address, the index of the base register and four control inputs: load or store, pre- or post-indexing, increment or decrement, and base write-back. The block then issues one 32-bit memory access for each set list bit. Accesses go in ascending register order at consecutive word addresses.

Store data comes from a combinational register-file read port. Load data goes back into the register file through a write port. The memory side uses a request/acknowledge handshake in which any number of wait cycles may pass before the acknowledge.

A decrement operation is converted into an ascending walk that starts from the lowest address. The block also applies the rules for a base register that appears in its own list. A done strobe closes each operation.

Top module: `multi_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `memReq` and `rfWrEn` are all low.
- R2: A non-empty list produces exactly one access per set bit, lowest register index first, with each address 4 above the previous one; `memWe` is 1 for a store and 0 for a load.
- R3: In increment mode the first address is the base plus 4 when pre-indexing and the base itself when post-indexing.
- R4: In decrement mode with N set bits the walk starts from base minus 4N and the indexing sense is inverted: pre-indexed decrement first accesses base minus 4N, post-indexed decrement first accesses base minus 4N plus 4.
- R5: With write-back, the base register receives base plus 4N in increment mode and base minus 4N in decrement mode; without write-back the block never writes the base register except as a load destination.
- R6: A store of a register other than the base sends the value read on `rfRdData` for the index shown on `rfRdIdx`.
- R7: A store whose list holds the base register sends the original base for that register when write-back is off or the base is the lowest set bit; otherwise it sends the write-back address.
- R8: A load writes the response data into the register being transferred, in the cycle the handshake completes.
- R9: A load with write-back whose list holds the base register writes the write-back address to the base after all transfers, unless the base is the highest set bit and other bits are also set, in which case the loaded value stays.
- R10: An empty list makes no memory access and no register write, and `done` rises in the cycle after the start strobe.
- R11: `done` is a one-cycle pulse that comes after the final memory response and after any base write-back; `busy` is low again in the following cycle.
- R12: Once `memReq` is raised it stays high with a stable `memAddr` until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; only taken while idle |
| isLoad | input | 1 | 1 = load-multiple, 0 = store-multiple |
| ctrlPre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| ctrlUp | input | 1 | 1 = increment, 0 = decrement |
| ctrlWb | input | 1 | 1 = write the final base back |
| regList | input | 16 | Register list, bit i selects register i |
| baseIdx | input | 4 | Index of the base register |
| baseVal | input | 32 | Current base register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data, combinational |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (store) |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory acknowledge; completes the request |
| memRdata | input | 32 | Load data, valid with memAck |

## Verification
Two register-file updates can target the same register: the load response into the base register and the base write-back. The design keeps them apart by committing the write-back in its own cycle after the final response. The bench provokes the clash with load lists in which the base is the only member, the highest member, or a middle member. Each case is judged by comparing all sixteen registers after `done` against the outcome R9 predicts: the write-back address where it applies, the loaded word otherwise. Memory acknowledges arrive after 0, 1 or 2 wait cycles, so the final response, the write-back and `done` land at different offsets from start.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef struct packed {
    logic capture;
    logic issue;
    logic advance;
    logic wbCommit;
    logic done;
  } seqStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_WBACK,
    ST_FINISH
  } seqState_t;
endpackage

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        listZero,
  input  logic        memAck,
  input  logic        lastXfer,
  input  logic        wbNeeded,
  output seqStrobes_t strobes,
  output logic        busy
);
  seqState_t stateQ, stateD;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.capture = 1'b1;
          stateD = listZero ? ST_FINISH : ST_XFER;
        end
      end
      ST_XFER: begin
        strobes.issue = 1'b1;
        if (memAck) begin
          strobes.advance = 1'b1;
          if (lastXfer) stateD = wbNeeded ? ST_WBACK : ST_FINISH;
        end
      end
      ST_WBACK: begin
        strobes.wbCommit = 1'b1;
        stateD = ST_FINISH;
      end
      default: begin
        strobes.done = 1'b1;
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> !strobes.done);

  // R10
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start && listZero) |=> strobes.done);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && !memAck) |=> strobes.issue);
endmodule

// File: rtl/mrt_datapath.sv
module mrt_datapath
  import mrt_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W   = $clog2(LIST_W),
  localparam int CNT_W   = IDX_W + 1,
  localparam int STEP    = DATA_W / 8,
  localparam int STEP_SH = $clog2(STEP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              isLoad,
  input  logic              ctrlPre,
  input  logic              ctrlUp,
  input  logic              ctrlWb,
  input  logic [LIST_W-1:0] regList,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              listZero,
  output logic              lastXfer,
  output logic              wbNeeded
);
  function automatic logic [CNT_W-1:0] popCount(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [LIST_W-1:0] pendQ, listQ;
  logic [DATA_W-1:0] addrQ, wbAddrQ, origQ;
  logic [IDX_W-1:0]  bIdxQ;
  logic              preQ, loadQ, wbQ;

  logic [DATA_W-1:0] spanC, lowC, wbC;
  always_comb begin
    spanC = DATA_W'(popCount(regList)) << STEP_SH;
    lowC  = ctrlUp ? baseVal : baseVal - spanC;
    wbC   = ctrlUp ? baseVal + spanC : baseVal - spanC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0; listQ <= '0; addrQ <= '0; wbAddrQ <= '0; origQ <= '0;
      bIdxQ <= '0; preQ <= 1'b0; loadQ <= 1'b0; wbQ <= 1'b0;
    end else if (strobes.capture) begin
      pendQ   <= regList;
      listQ   <= regList;
      addrQ   <= lowC;
      wbAddrQ <= wbC;
      origQ   <= baseVal;
      bIdxQ   <= baseIdx;
      preQ    <= ctrlUp ? ctrlPre : !ctrlPre;
      loadQ   <= isLoad;
      wbQ     <= ctrlWb;
    end else if (strobes.advance) begin
      pendQ[rfRdIdx] <= 1'b0;
      addrQ <= addrQ + DATA_W'(STEP);
    end
  end

  // Lowest pending register (priority find)
  always_comb begin
    rfRdIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (pendQ[i]) rfRdIdx = IDX_W'(i);
  end

  logic [LIST_W-1:0] baseBit, belowMask, aboveMask;
  logic baseInList, baseLowest, baseHighest, onlyBase;
  always_comb begin
    baseBit     = LIST_W'(1) << bIdxQ;
    belowMask   = baseBit - LIST_W'(1);
    aboveMask   = ~(belowMask | baseBit);
    baseInList  = |(listQ & baseBit);
    baseLowest  = (listQ & belowMask) == '0;
    baseHighest = baseInList && ((listQ & aboveMask) == '0);
    onlyBase    = (listQ == baseBit);
  end

  assign listZero = (regList == '0);
  assign lastXfer = (pendQ & (pendQ - LIST_W'(1))) == '0;
  assign wbNeeded = wbQ && !(loadQ && baseHighest && !onlyBase);

  assign memAddr  = preQ ? addrQ + DATA_W'(STEP) : addrQ;
  assign memWe    = strobes.issue && !loadQ;
  assign memWdata = (rfRdIdx != bIdxQ) ? rfRdData :
                    ((baseLowest || !wbQ) ? origQ : wbAddrQ);

  assign rfWrEn   = (strobes.advance && loadQ) || strobes.wbCommit;
  assign rfWrIdx  = strobes.wbCommit ? bIdxQ : rfRdIdx;
  assign rfWrData = strobes.wbCommit ? wbAddrQ : memRdata;

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && !strobes.advance) |=> $stable(memAddr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !lastXfer) |=> memAddr == $past(memAddr) + DATA_W'(STEP));

  // R11
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |-> (pendQ == '0));
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import mrt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isLoad,
  input  logic        ctrlPre,
  input  logic        ctrlUp,
  input  logic        ctrlWb,
  input  logic [15:0] regList,
  input  logic [3:0]  baseIdx,
  input  logic [31:0] baseVal,
  output logic        busy,
  output logic        done,
  output logic [3:0]  rfRdIdx,
  input  logic [31:0] rfRdData,
  output logic        rfWrEn,
  output logic [3:0]  rfWrIdx,
  output logic [31:0] rfWrData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata
);
  seqStrobes_t strobes;
  logic listZero, lastXfer, wbNeeded;

  mrt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .listZero(listZero),
    .memAck(memAck), .lastXfer(lastXfer), .wbNeeded(wbNeeded),
    .strobes(strobes), .busy(busy)
  );

  mrt_datapath #(.LIST_W(16), .DATA_W(32)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .isLoad(isLoad), .ctrlPre(ctrlPre), .ctrlUp(ctrlUp), .ctrlWb(ctrlWb),
    .regList(regList), .baseIdx(baseIdx), .baseVal(baseVal),
    .rfRdData(rfRdData), .memRdata(memRdata),
    .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .listZero(listZero), .lastXfer(lastXfer), .wbNeeded(wbNeeded)
  );

  assign memReq = strobes.issue;
  assign done   = strobes.done;
endmodule

// File: tb/multi_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module multi_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, isLoad = 0, ctrlPre = 0, ctrlUp = 0, ctrlWb = 0;
  logic [15:0] regList = '0;
  logic [3:0]  baseIdx = '0;
  logic [31:0] baseVal = '0;
  logic busy, done, rfWrEn, memReq, memWe;
  logic [3:0] rfRdIdx, rfWrIdx;
  logic [31:0] rfRdData, rfWrData, memAddr, memWdata;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  logic [31:0] rf [16];
  logic [31:0] mem [64];
  assign rfRdData = rf[rfRdIdx];

  multi_xfer_seq dut_i (.*);

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; string tag; } acc_t;
  acc_t expQ[$];
  int nChk = 0, nBad = 0;
  int waitCnt = 0, latSel = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model and scoreboard monitor
  always @(negedge clk) begin
    memAck = 1'b0;
    if (rstN && memReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        acc_t e;
        memAck   = 1'b1;
        memRdata = mem[memAddr[7:2]];
        if (expQ.size() == 0) check(0, "R2 unexpected access", memAddr, 32'h0);
        else begin
          e = expQ.pop_front();
          check(e.we === memWe && e.addr === memAddr, {e.tag, " addr/dir"}, memAddr, e.addr);
          if (e.we) check(e.data === memWdata, {e.tag, " store data"}, memWdata, e.data);
        end
        if (memWe) mem[memAddr[7:2]] = memWdata;
        latSel++;
        waitCnt = latSel % 3;
      end
    end
  end

  // Register-file write port
  always @(negedge clk) begin
    #1;
    if (rstN && rfWrEn) rf[rfWrIdx] = rfWrData;
  end

  task automatic initRf(input logic [3:0] bIdx, input logic [31:0] bVal);
    for (int i = 0; i < 16; i++) rf[i] = 32'h5100_0000 + 32'(i) * 32'h0001_0203;
    rf[bIdx] = bVal;
  endtask

  task automatic runOp(input bit ld, input bit pre, input bit up, input bit wb,
                       input logic [15:0] list, input logic [3:0] bIdx,
                       input logic [31:0] bVal, input string tag);
    logic [31:0] erf [16];
    logic [31:0] span, low, wbA, a;
    logic [15:0] bb;
    bit pe, lowest, highest, only;
    int n, cyc;
    acc_t it;
    initRf(bIdx, bVal);
    for (int i = 0; i < 16; i++) erf[i] = rf[i];
    n = $countones(list);
    span = 32'(n * 4);
    low = up ? bVal : bVal - span;
    wbA = up ? bVal + span : bVal - span;
    pe = up ? pre : !pre;
    bb = 16'h1 << bIdx;
    lowest  = (list & (bb - 16'h1)) == 0;
    highest = (list >> bIdx) == 16'h1;
    only    = (list == bb);
    a = low;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        if (pe) a = a + 4;
        it.addr = a; it.we = !ld; it.tag = tag;
        if (!ld) it.data = (4'(i) == bIdx) ? ((lowest || !wb) ? bVal : wbA) : rf[i];
        else begin it.data = mem[a[7:2]]; erf[i] = mem[a[7:2]]; end
        expQ.push_back(it);
        if (!pe) a = a + 4;
      end
    end
    if (wb && n > 0 && !(ld && list[bIdx] && highest && !only)) erf[bIdx] = wbA;

    @(negedge clk);
    isLoad = ld; ctrlPre = pre; ctrlUp = up; ctrlWb = wb;
    regList = list; baseIdx = bIdx; baseVal = bVal; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(done === 1'b1, {tag, " R11 done seen"}, 32'(done), 32'h1);
    if (n == 0) check(cyc == 1, {tag, " R10 done latency"}, 32'(cyc), 32'h1);
    check(expQ.size() == 0, {tag, " R11 all responses before done"}, 32'(expQ.size()), 32'h0);
    expQ.delete();
    @(negedge clk); #1.5;
    for (int i = 0; i < 16; i++)
      check(rf[i] === erf[i], $sformatf("%s reg %0d", tag, i), rf[i], erf[i]);
    check(done === 1'b0 && busy === 1'b0, {tag, " R11 single pulse"}, {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'hC000_0000 | (32'(k) << 8) | 32'(k);
    initRf(4'd0, 32'h0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 0 && done === 0 && memReq === 0 && rfWrEn === 0, "R1 reset idle",
          {28'h0, busy, done, memReq, rfWrEn}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 0 && memReq === 0, "R1 idle after reset", {30'h0, busy, memReq}, 32'h0);

    runOp(0, 0, 1, 1, 16'h00F0, 4'd13, 32'h40, "R2 R3 R5 R6 R12 store inc-post");
    runOp(0, 1, 1, 0, 16'h0111, 4'd3,  32'h60, "R3 R6 store inc-pre");
    runOp(0, 1, 0, 1, 16'h0E01, 4'd13, 32'hC0, "R4 R5 store dec-pre");
    runOp(0, 0, 0, 1, 16'h8003, 4'd12, 32'hC0, "R4 R5 store dec-post");
    runOp(1, 0, 1, 1, 16'h0F00, 4'd1,  32'h20, "R8 R5 load inc-post");
    runOp(1, 1, 0, 0, 16'h00E0, 4'd0,  32'h80, "R4 R8 load dec-pre");
    runOp(0, 0, 1, 1, 16'h0C10, 4'd4,  32'h50, "R7 store base lowest");
    runOp(0, 0, 1, 1, 16'h0C11, 4'd4,  32'h50, "R7 store base not lowest");
    runOp(0, 1, 0, 0, 16'h0C11, 4'd4,  32'h90, "R7 store base no writeback");
    runOp(1, 0, 1, 1, 16'h0008, 4'd3,  32'h30, "R9 load base only");
    runOp(1, 0, 1, 1, 16'h1006, 4'd12, 32'h70, "R9 load base highest");
    runOp(1, 1, 0, 1, 16'h1206, 4'd9,  32'h70, "R9 load base middle");
    runOp(0, 0, 1, 1, 16'h0000, 4'd5,  32'h44, "R10 empty list");
    runOp(1, 1, 1, 1, 16'hFFFF, 4'd15, 32'h00, "R2 R9 full load");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule